// File: doc/BRIEF.md
# Adaptive BCH Syndrome Calculator

This block is the front stage of a binary BCH decoder whose correction strength `t` is chosen per codeword at run time. A codeword of `K` message bits plus `M*t` parity bits arrives as `P`-bit words, most significant word first. The block divides the codeword by the minimal polynomial of each power of the field generator in a bank of `2*TMAX` word-parallel remainder registers. Only the first `2t` registers are active for the selected strength. When the last word has been taken, it turns each remainder into a field element, which is the syndrome.

A codeword length that is not a whole number of words is handled by alignment. The upstream source puts the codeword in the low bits of the word stream. The unused top bits of the first word are forced to zero, and zero high-order terms leave every remainder unchanged. On a single done strobe the block presents the syndrome vector and a clean flag. The clean flag says every active remainder is zero, so the later error-location stages can be skipped.

Top module: `bch_syndrome_calc`

## Requirements
- R1: A codeword starts with a word where `valid_i` and `start_i` are both high. It occupies `Wt = ceil((K+M*t)/P)` accepted words. `done_o` is high for exactly one cycle, in the cycle after the last word is accepted. A new codeword may start in the cycle right after the last word of the previous one.
- R2: At done, the syndrome field `j` (bits `[(j-1)*M +: M]` of `syn_o`, with j from 1 to 2t) equals c(α^j). Here codeword bit k is the coefficient of x^k, and the LSB of the last word is x^0. Arithmetic is in GF(2^M) with primitive polynomial `POLY` (default x^5+x^2+1), and α is the element 0b00010.
- R3: At done, every syndrome field j > 2t reads zero.
- R4: At done, `clean_o` is 1 exactly when all active remainders are zero. It is 1 for an unaltered codeword and 0 for a codeword carrying between 1 and t flipped bits.
- R5: The first word of a codeword carries `Wt*P-(K+M*t)` pad bits in its most significant positions. Their values have no effect on `syn_o` or `clean_o`.
- R6: Cycles with `valid_i` low inside a codeword are not counted and leave the result unchanged.
- R7: A word with `valid_i` high and `start_i` low, arriving while no codeword is in progress, is ignored. It produces no done strobe and leaves `syn_o` and `clean_o` unchanged.
- R8: A start word that arrives while a codeword is in progress abandons that codeword and begins a new one.
- R9: `t_i` is sampled on the start word only. The value 0 is treated as 1, and values above `TMAX` are treated as `TMAX`.
- R10: Reset clears `done_o`, `clean_o` and `syn_o` to zero. Between done strobes, `syn_o` and `clean_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input word is present |
| start_i | input | 1 | Present word is the first of a codeword |
| t_i | input | TW = $clog2(TMAX+1) | Correction strength, sampled with the start word |
| data_i | input | P | Codeword word, most significant bit first |
| done_o | output | 1 | One-cycle strobe: results valid |
| clean_o | output | 1 | All active remainders were zero |
| syn_o | output | 2*TMAX*M | Syndrome j in bits [(j-1)*M +: M] |

## Verification
A remainder register that drifts shows up only at the next done strobe, as a wrong syndrome field. A disabled lane that does not hold zero shows up as a nonzero field above 2t. A word counter that is off by one moves the done strobe by a cycle and shifts every remainder. The bench therefore compares all syndrome fields and the clean flag in the exact cycle of the strobe. It also watches the same outputs across idle cycles, stray words, stalls and restarted codewords, where any leak would appear one cycle after the offending word.

// File: rtl/bchs_pkg.sv
package bchs_pkg;

   // Multiply two elements of GF(2^m), reduced by the primitive polynomial prim.
   function automatic logic [15:0] gf_mul(input logic [15:0] a, input logic [15:0] b,
                                          input int m, input logic [16:0] prim);
      logic [16:0] acc;
      logic [16:0] aa;
      acc = '0;
      aa  = {1'b0, a};
      for (int k = 0; k < 16; k++) begin
         if (k < m) begin
            if (b[k]) acc ^= aa;
            aa = aa << 1;
            if (aa[m]) aa ^= prim;
         end
      end
      return acc[15:0];
   endfunction

   // alpha^e by square and multiply.
   function automatic logic [15:0] gf_pow(input int e, input int m, input logic [16:0] prim);
      logic [15:0] r;
      logic [15:0] b;
      r = 16'd1;
      b = 16'd2;
      for (int k = 0; k < 16; k++) begin
         if (e[k]) r = gf_mul(r, b, m, prim);
         b = gf_mul(b, b, m, prim);
      end
      return r;
   endfunction

   // Minimal polynomial of alpha^idx as a binary coefficient vector.
   function automatic logic [16:0] min_poly(input int idx, input int m, input logic [16:0] prim);
      logic [16:0][15:0] c;
      logic [16:0]       res;
      logic [15:0]       beta;
      int                q;
      int                e;
      int                e0;
      int                deg;
      bit                stop;
      q    = (1 << m) - 1;
      e0   = idx % q;
      e    = e0;
      deg  = 0;
      stop = 1'b0;
      c    = '0;
      c[0] = 16'd1;
      for (int k = 0; k < 16; k++) begin
         if (k >= m || (k > 0 && e == e0)) stop = 1'b1;
         if (!stop) begin
            beta = gf_pow(e, m, prim);
            for (int j = 16; j >= 1; j--) begin
               if (j <= deg + 1) c[j] = c[j-1] ^ gf_mul(c[j], beta, m, prim);
            end
            c[0] = gf_mul(c[0], beta, m, prim);
            deg++;
            e = (e * 2) % q;
         end
      end
      for (int j = 0; j < 17; j++) res[j] = c[j][0];
      return res;
   endfunction

   function automatic int poly_deg(input logic [16:0] p);
      int d;
      d = 0;
      for (int j = 0; j < 17; j++) if (p[j]) d = j;
      return d;
   endfunction

endpackage

// File: rtl/bchs_word_ctl.sv
module bchs_word_ctl #(
   parameter int K    = 16,
   parameter int M    = 5,
   parameter int P    = 4,
   parameter int TMAX = 3,
   localparam int TW    = $clog2(TMAX + 1),
   localparam int NL    = 2 * TMAX,
   localparam int WMAX  = (K + M * TMAX + P - 1) / P,
   localparam int CW    = $clog2(WMAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  logic          start_i,
   input  logic [TW-1:0] t_i,
   input  logic [P-1:0]  data_i,
   output logic          accept_o,
   output logic          first_o,
   output logic          last_o,
   output logic [NL-1:0] en_o,
   output logic [P-1:0]  data_o
);

   function automatic int words_of(input int tt);
      return (K + M * tt + P - 1) / P;
   endfunction

   function automatic int pad_of(input int tt);
      return words_of(tt) * P - (K + M * tt);
   endfunction

   logic          busy_q;
   logic [CW-1:0] cnt_q;
   logic [TW-1:0] t_q;
   int            t_eff;
   int            t_sel;
   int            cnt_nxt;

   always_comb begin
      if (t_i == '0)              t_eff = 1;
      else if (int'(t_i) > TMAX)  t_eff = TMAX;
      else                        t_eff = int'(t_i);
      t_sel    = start_i ? t_eff : int'(t_q);
      accept_o = valid_i && (start_i || busy_q);
      first_o  = valid_i && start_i;
      cnt_nxt  = start_i ? 1 : int'(cnt_q) + 1;
      last_o   = accept_o && (cnt_nxt == words_of(t_sel));
      for (int i = 0; i < NL; i++) en_o[i] = (i < 2 * t_sel);
      data_o   = first_o ? (data_i & ({P{1'b1}} >> pad_of(t_sel))) : data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         t_q    <= TW'(1);
      end else if (accept_o) begin
         busy_q <= !last_o;
         cnt_q  <= CW'(cnt_nxt);
         t_q    <= TW'(t_sel);
      end
   end

   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (int'(cnt_q) < words_of(int'(t_q))));

   p_stray_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !start_i && !busy_q) |-> !last_o);

   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && start_i) |=> (int'(cnt_q) == 1));

endmodule

// File: rtl/bchs_rem_lfsr.sv
module bchs_rem_lfsr #(
   parameter int          M    = 5,
   parameter int          P    = 4,
   parameter logic [16:0] PRIM = 17'h25,
   parameter int          IDX  = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         accept_i,
   input  logic         first_i,
   input  logic         en_i,
   input  logic [P-1:0] data_i,
   output logic [M-1:0] rem_nxt_o
);

   localparam logic [16:0] PSI = bchs_pkg::min_poly(IDX, M, PRIM);
   localparam int          D   = bchs_pkg::poly_deg(PSI);

   logic [M-1:0] rem_q;
   logic [M-1:0] r;
   logic [M:0]   tmp;

   always_comb begin
      r   = first_i ? '0 : rem_q;
      tmp = '0;
      for (int b = P - 1; b >= 0; b--) begin
         tmp = {r, data_i[b]};
         if (tmp[D]) tmp ^= PSI[M:0];
         r = tmp[M-1:0];
      end
      rem_nxt_o = en_i ? r : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rem_q <= '0;
      else if (accept_i) rem_q <= rem_nxt_o;
   end

   p_off_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && !en_i) |=> (rem_q == '0));

endmodule

// File: rtl/bchs_syn_map.sv
module bchs_syn_map #(
   parameter int          M    = 5,
   parameter logic [16:0] PRIM = 17'h25,
   parameter int          IDX  = 1,
   localparam int         Q    = (1 << M) - 1
) (
   input  logic [M-1:0] rem_i,
   output logic [M-1:0] syn_o
);

   logic [M-1:0] term [M];

   for (genvar k = 0; k < M; k++) begin : g_col
      localparam logic [15:0] AK = bchs_pkg::gf_pow((IDX * k) % Q, M, PRIM);
      assign term[k] = rem_i[k] ? AK[M-1:0] : '0;
   end

   always_comb begin
      syn_o = '0;
      for (int k = 0; k < M; k++) syn_o ^= term[k];
   end

endmodule

// File: rtl/bch_syndrome_calc.sv
module bch_syndrome_calc #(
   parameter int         K    = 16,
   parameter int         M    = 5,
   parameter int         P    = 4,
   parameter int         TMAX = 3,
   parameter logic [M:0] POLY = 6'b100101,
   localparam int TW   = $clog2(TMAX + 1),
   localparam int NL   = 2 * TMAX,
   localparam int SW   = NL * M
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  logic          start_i,
   input  logic [TW-1:0] t_i,
   input  logic [P-1:0]  data_i,
   output logic          done_o,
   output logic          clean_o,
   output logic [SW-1:0] syn_o
);

   localparam logic [16:0] PRIM = 17'(POLY);

   if (M < 3 || M > 16) begin : g_bad_m
      $error("field degree out of range");
   end
   if (K + M * TMAX > (1 << M) - 1) begin : g_bad_len
      $error("codeword longer than field order");
   end
   if (K + M <= P) begin : g_bad_p
      $error("codeword must span at least two words");
   end
   if (POLY[M] != 1'b1 || POLY[0] != 1'b1) begin : g_bad_poly
      $error("field polynomial malformed");
   end

   logic          accept;
   logic          first;
   logic          last;
   logic [NL-1:0] en;
   logic [P-1:0]  data_al;
   logic [NL-1:0] lane_zero;
   logic [SW-1:0] syn_nxt;

   bchs_word_ctl #(.K(K), .M(M), .P(P), .TMAX(TMAX)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (valid_i),
      .start_i  (start_i),
      .t_i      (t_i),
      .data_i   (data_i),
      .accept_o (accept),
      .first_o  (first),
      .last_o   (last),
      .en_o     (en),
      .data_o   (data_al)
   );

   for (genvar g = 0; g < NL; g++) begin : g_lane
      logic [M-1:0] rem_nxt;

      bchs_rem_lfsr #(.M(M), .P(P), .PRIM(PRIM), .IDX(g + 1)) u_rem (
         .clk       (clk),
         .rst_n     (rst_n),
         .accept_i  (accept),
         .first_i   (first),
         .en_i      (en[g]),
         .data_i    (data_al),
         .rem_nxt_o (rem_nxt)
      );

      bchs_syn_map #(.M(M), .PRIM(PRIM), .IDX(g + 1)) u_map (
         .rem_i (rem_nxt),
         .syn_o (syn_nxt[g*M +: M])
      );

      assign lane_zero[g] = (rem_nxt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         clean_o <= 1'b0;
         syn_o   <= '0;
      end else begin
         done_o <= last;
         if (last) begin
            clean_o <= &lane_zero;
            syn_o   <= syn_nxt;
         end
      end
   end

   p_clean_matches_syn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (clean_o == (syn_o == '0)));

   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_syn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(syn_o) |-> done_o);

   p_clean_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clean_o) |-> done_o);

endmodule

// File: tb/tb_bch_syndrome_calc.sv
`timescale 1ns/1ps
module tb_bch_syndrome_calc;

   localparam int K = 16, M = 5, P = 4, TMAX = 3;
   localparam int SW = 2 * TMAX * M;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_i = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    t_i = 2'd1;
   logic [P-1:0]  data_i = '0;
   logic          done_o;
   logic          clean_o;
   logic [SW-1:0] syn_o;

   bch_syndrome_calc #(.K(K), .M(M), .P(P), .TMAX(TMAX)) dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .start_i(start_i),
      .t_i(t_i), .data_i(data_i), .done_o(done_o), .clean_o(clean_o), .syn_o(syn_o)
   );

   always #2 clk = ~clk;

   int nchk = 0;
   int nfail = 0;

   typedef struct packed {
      logic [1:0]  t;
      logic [15:0] msg;
      logic [4:0]  e0;
      logic [4:0]  e1;
      logic [4:0]  e2;
      logic        junk;
      logic        stall;
   } row_t;

   // error position 31 means no error
   localparam row_t ROWS [12] = '{
      '{2'd1, 16'hA5C3, 5'd31, 5'd31, 5'd31, 1'b0, 1'b0},
      '{2'd1, 16'h1234, 5'd7,  5'd31, 5'd31, 1'b0, 1'b0},
      '{2'd2, 16'hFFFF, 5'd31, 5'd31, 5'd31, 1'b1, 1'b0},
      '{2'd2, 16'h0001, 5'd0,  5'd25, 5'd31, 1'b0, 1'b0},
      '{2'd3, 16'hBEEF, 5'd31, 5'd31, 5'd31, 1'b0, 1'b0},
      '{2'd3, 16'h0F0F, 5'd30, 5'd15, 5'd1,  1'b0, 1'b1},
      '{2'd3, 16'h0000, 5'd31, 5'd31, 5'd31, 1'b0, 1'b0},
      '{2'd0, 16'h4321, 5'd3,  5'd31, 5'd31, 1'b1, 1'b0},
      '{2'd2, 16'h8000, 5'd12, 5'd31, 5'd31, 1'b1, 1'b1},
      '{2'd3, 16'h7777, 5'd4,  5'd5,  5'd31, 1'b0, 1'b0},
      '{2'd1, 16'hFFFF, 5'd20, 5'd31, 5'd31, 1'b1, 1'b0},
      '{2'd2, 16'h5A5A, 5'd31, 5'd31, 5'd31, 1'b0, 1'b1}
   };

   function automatic logic [4:0] fmul(input logic [4:0] a, input logic [4:0] b);
      logic [9:0] prod;
      prod = '0;
      for (int i = 0; i < 5; i++) if (b[i]) prod ^= (10'(a) << i);
      for (int i = 9; i >= 5; i--) if (prod[i]) prod ^= (10'b100101 << (i - 5));
      return prod[4:0];
   endfunction

   function automatic logic [4:0] fpow(input int e);
      logic [4:0] r;
      r = 5'd1;
      for (int i = 0; i < e % 31; i++) r = fmul(r, 5'd2);
      return r;
   endfunction

   // generator polynomial: product of (x + alpha^e) over conjugates of 1..2t
   function automatic logic [31:0] gen_poly(input int t);
      logic [30:0]      mark;
      logic [4:0]       c [32];
      logic [31:0]      res;
      int               deg;
      mark = '0;
      for (int j = 1; j <= 2 * t; j++) begin
         int e;
         e = j % 31;
         for (int k = 0; k < 5; k++) begin
            mark[e] = 1'b1;
            e = (e * 2) % 31;
         end
      end
      for (int i = 0; i < 32; i++) c[i] = '0;
      c[0] = 5'd1;
      deg = 0;
      for (int e = 0; e < 31; e++) begin
         if (mark[e]) begin
            for (int j = deg + 1; j >= 1; j--) c[j] = c[j-1] ^ fmul(c[j], fpow(e));
            c[0] = fmul(c[0], fpow(e));
            deg++;
         end
      end
      for (int i = 0; i < 32; i++) res[i] = c[i][0];
      return res;
   endfunction

   logic          pend = 1'b0;
   logic [SW-1:0] exp_syn = '0;
   logic          exp_clean = 1'b0;
   string         exp_tag = "";

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_pending();
      if (pend) begin
         chk("R1", {exp_tag, " done"}, 32'(done_o), 32'd1);
         chk("R2", {exp_tag, " syndromes"}, 32'(syn_o), 32'(exp_syn));
         chk("R4", {exp_tag, " clean"}, 32'(clean_o), 32'(exp_clean));
         pend = 1'b0;
      end
   endtask

   task automatic send_cw(input string tag, input int tr, input logic [15:0] msg,
                          input int e0, input int e1, input int e2,
                          input bit junk, input bit stall);
      int          t;
      int          n;
      int          w;
      logic [31:0] g;
      logic [31:0] c;
      logic [SW-1:0] es;
      t = (tr == 0) ? 1 : tr;
      n = K + M * t;
      w = (n + P - 1) / P;
      g = gen_poly(t);
      c = '0;
      for (int i = 0; i < 16; i++) if (msg[i]) c ^= (g << i);
      if (e0 < 31) c[e0] = ~c[e0];
      if (e1 < 31) c[e1] = ~c[e1];
      if (e2 < 31) c[e2] = ~c[e2];
      es = '0;
      for (int j = 1; j <= 2 * t; j++) begin
         logic [4:0] s;
         s = '0;
         for (int k = 0; k < n; k++) if (c[k]) s ^= fpow(j * k);
         es[(j-1)*M +: M] = s;
      end
      if (junk) for (int k = n; k < 32; k++) c[k] = 1'b1;
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         check_pending();
         if (stall && i == 2) begin
            valid_i = 1'b0; start_i = 1'b0; data_i = 4'hF;
            @(negedge clk);
         end
         valid_i = 1'b1;
         start_i = (i == 0);
         t_i     = 2'(tr);
         data_i  = c[(w-1-i)*P +: P];
      end
      exp_syn   = es;
      exp_clean = (e0 == 31 && e1 == 31 && e2 == 31);
      exp_tag   = tag;
      pend      = 1'b1;
   endtask

   task automatic go_idle();
      @(negedge clk);
      check_pending();
      valid_i = 1'b0; start_i = 1'b0; data_i = '0;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      nfail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [SW-1:0] held;
      logic          held_c;
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10", "reset done", 32'(done_o), 32'd0);
      chk("R10", "reset clean", 32'(clean_o), 32'd0);
      chk("R10", "reset syn", 32'(syn_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R5 (junk pad) R6 (stall) R9 (t=0 as 1)
      for (int r = 0; r < 12; r++) begin
         send_cw($sformatf("row%0d", r), int'(ROWS[r].t), ROWS[r].msg, int'(ROWS[r].e0),
                 int'(ROWS[r].e1), int'(ROWS[r].e2), ROWS[r].junk, ROWS[r].stall);
         go_idle();
      end

      // R10: outputs hold between done strobes; R3: upper fields of t=2 result zero
      send_cw("r3_hold", 2, 16'h3C3C, 9, 31, 31, 1'b0, 1'b0);
      go_idle();
      held = syn_o; held_c = clean_o;
      chk("R3", "fields above 2t", 32'(syn_o[SW-1:4*M]), 32'd0);
      repeat (4) @(negedge clk);
      chk("R10", "syn held", 32'(syn_o), 32'(held));
      chk("R10", "clean held", 32'(clean_o), 32'(held_c));
      chk("R10", "no done while idle", 32'(done_o), 32'd0);

      // R7: stray word while idle is ignored
      valid_i = 1'b1; start_i = 1'b0; data_i = 4'hA;
      @(negedge clk);
      valid_i = 1'b0;
      chk("R7", "stray done", 32'(done_o), 32'd0);
      @(negedge clk);
      chk("R7", "stray done later", 32'(done_o), 32'd0);
      chk("R7", "stray syn unchanged", 32'(syn_o), 32'(held));

      // R8: restart mid-codeword, previous partial words discarded
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         valid_i = 1'b1; start_i = (i == 0); t_i = 2'd3; data_i = 4'h9;
      end
      send_cw("r8_restart", 1, 16'hC001, 31, 31, 31, 1'b0, 1'b0);
      // R1: back-to-back codewords, next start right after last word
      send_cw("r1_b2b_a", 3, 16'h0246, 2, 31, 31, 1'b1, 1'b0);
      send_cw("r1_b2b_b", 2, 16'hF00D, 31, 31, 31, 1'b0, 1'b0);
      go_idle();
      @(negedge clk);
      chk("R1", "single-cycle done", 32'(done_o), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule